// File: doc/BRIEF.md
# Key-Combination Reset Generator

This block watches a stream of input events and raises a reset pulse when a programmed combination of up to three events is active together. Each event arrives as a one-cycle strobe carrying a 7-bit code and a polarity flag: 1 for a key press or an input going active, 0 for a release or an input going inactive. Three configuration slots each hold a 7-bit code and a polarity bit, and they are written through a small register port.

Each slot keeps a held flag. The flag is set when an event with the slot's code arrives with the chosen polarity. It is cleared when an event with that code arrives with the other polarity. A slot with code zero is disabled. When every enabled slot is held at once, the block drives the reset output high for a fixed number of cycles. It then waits until the combination has been broken before it can fire again. Writing a slot clears that slot's held flag, so a condition left over from an old setting cannot cause a reset.

Top module: `keycombo_rst`

## Requirements
- R1: A write with `cfg_we`=1 and `cfg_sel` of 0, 1 or 2 loads that slot: `cfg_data[6:0]` is the event code and `cfg_data[7]` is the polarity bit. A `cfg_sel` of 3 loads nothing.
- R2: A slot whose code is zero is disabled and has no part in the combination.
- R3: The reset fires only when every enabled slot is held in the same cycle.
- R4: With polarity bit 1, an event with `evt_press`=1 sets the slot's held flag and an event with `evt_press`=0 clears it.
- R5: With polarity bit 0, an event with `evt_press`=0 sets the held flag and an event with `evt_press`=1 clears it.
- R6: When all three slots are zero, `rst_out` never goes high.
- R7: `rst_out` goes high on the second rising edge after the completing event is sampled, and it stays high for exactly `PULSE_W` cycles (16 by default).
- R8: After a pulse the block does not fire again until the combination has stopped holding at least once.
- R9: A slot write clears that slot's held flag. If a write and a matching event fall in the same cycle, the write wins.
- R10: An event whose code matches no slot, or whose code is zero, changes no held flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event strobe, one cycle per event |
| evt_code | input | 7 | Event code, 1 to 127 |
| evt_press | input | 1 | 1 = press or active, 0 = release or inactive |
| cfg_we | input | 1 | Slot write enable |
| cfg_sel | input | 2 | Slot index, 0 to 2 |
| cfg_data | input | 8 | Bit 7 is the polarity, bits 6:0 are the code |
| rst_out | output | 1 | Active-high reset pulse |

## Verification
A slot write and a matching event for the same slot can fall in the same clock cycle. The bench provokes this by driving both strobes in one cycle while the other slots are already held. The write must win: the slot stays clear and no pulse appears, which is confirmed by watching `rst_out` and then sending a fresh event that completes the combination. A second case is re-arming at the end of a pulse while the combination still holds. The bench checks that no new pulse starts until a release has broken the combination.

// File: rtl/keycombo_pkg.sv
package keycombo_pkg;
    localparam int CODE_W  = 7;
    localparam int CFG_W   = CODE_W + 1;
    localparam int N_SLOTS = 3;
    localparam int SEL_W   = 2;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              level;
        logic              held;
    } slot_st_t;
endpackage

// File: rtl/keycombo_slot.sv
module keycombo_slot
    import keycombo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_W-1:0]  wdata,
    input  logic              evt_valid,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              evt_press,
    output logic              enabled,
    output logic              held
);
    slot_st_t st_d, st_q;
    logic     match;

    always_comb begin
        st_d  = st_q;
        match = evt_valid && (evt_code != '0) && (evt_code == st_q.code);
        if (we) begin
            st_d.code  = wdata[CODE_W-1:0];
            st_d.level = wdata[CFG_W-1];
            st_d.held  = 1'b0;
        end else if (match) begin
            st_d.held  = (evt_press == st_q.level);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enabled = (st_q.code != '0);
    assign held    = st_q.held;

    // R2
    held_needs_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.held |-> (st_q.code != '0));

    // R9
    write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !st_q.held);

    // R10
    held_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.held) |-> $past(evt_valid) && ($past(evt_code) == $past(st_q.code)));
endmodule

// File: rtl/keycombo_pulse.sv
module keycombo_pulse #(
    parameter int PULSE_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic combo,
    output logic pulse
);
    localparam int CW = $clog2(PULSE_W + 1);

    typedef struct packed {
        logic          armed;
        logic          active;
        logic [CW-1:0] cnt;
    } pulse_st_t;

    pulse_st_t st_d, st_q;
    logic      fire;

    always_comb begin
        st_d = st_q;
        fire = combo && st_q.armed && !st_q.active;
        if (fire) begin
            st_d.active = 1'b1;
            st_d.cnt    = CW'(PULSE_W - 1);
            st_d.armed  = 1'b0;
        end else begin
            if (!combo) st_d.armed = 1'b1;
            if (st_q.active) begin
                if (st_q.cnt == '0) st_d.active = 1'b0;
                else                st_d.cnt    = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed  <= 1'b1;
            st_q.active <= 1'b0;
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.active;

    // R8
    fire_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> $past(st_q.armed) && $past(combo));

    // R7
    pulse_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.cnt != '0) |=> st_q.active);

    // R7
    pulse_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.active) |-> ($past(st_q.cnt) == '0));
endmodule

// File: rtl/keycombo_rst.sv
module keycombo_rst
    import keycombo_pkg::*;
#(
    parameter int PULSE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              evt_press,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_data,
    output logic              rst_out
);
    logic [N_SLOTS-1:0] en_w, held_w;
    logic               combo;

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        keycombo_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (cfg_we && (cfg_sel == SEL_W'(i))),
            .wdata     (cfg_data),
            .evt_valid (evt_valid),
            .evt_code  (evt_code),
            .evt_press (evt_press),
            .enabled   (en_w[i]),
            .held      (held_w[i])
        );
    end

    assign combo = (|en_w) && (&(held_w | ~en_w));

    keycombo_pulse #(.PULSE_W(PULSE_W)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .combo (combo),
        .pulse (rst_out)
    );

    // R6
    needs_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> $past(|en_w));

    // R3
    all_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> $past((held_w & en_w) == en_w));
endmodule

// File: tb/sim_keycombo_rst.sv
`timescale 1ns/1ps
module sim_keycombo_rst;
    localparam int PW = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_valid = 1'b0;
    logic [6:0] evt_code = '0;
    logic       evt_press = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_data = '0;
    logic       rst_out;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    keycombo_rst #(.PULSE_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
        .evt_press(evt_press), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .rst_out(rst_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic lvl, input logic [6:0] code);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_data = {lvl, code};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ev(input logic [6:0] code, input logic press);
        @(negedge clk);
        evt_valid = 1'b1; evt_code = code; evt_press = press;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    // Leaves the caller at the negedge after the event edge. Checks that the
    // pulse rises one edge later and lasts PW cycles.
    task automatic expect_pulse(input string req);
        int n = 0;
        chk({req, " low before rise"}, int'(rst_out), 0);
        @(negedge clk);
        chk({req, " rise"}, int'(rst_out), 1);
        while (rst_out && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk({req, " width"}, n, PW);
    endtask

    task automatic expect_quiet(input string req, input int cyc);
        int hits = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (rst_out) hits++;
        end
        chk({req, " quiet"}, hits, 0);
    endtask

    task automatic clear_all();
        for (int s = 0; s < 3; s++) wr(s, 1'b0, 7'd0);
        expect_quiet("clear", 3);
    endtask

    task automatic t_reset();
        chk("R7 reset state", int'(rst_out), 0);
    endtask

    task automatic t_all_zero();  // R6
        ev(7'h15, 1'b1);
        ev(7'h00, 1'b1);
        ev(7'h33, 1'b0);
        expect_quiet("R6 all slots zero", 20);
    endtask

    task automatic t_single();  // R1 R4 R7 R8
        wr(1, 1'b1, 7'h15);
        ev(7'h15, 1'b1);
        expect_pulse("R7 single press");
        expect_quiet("R8 no retrigger while held", 20);
        ev(7'h15, 1'b0);
        expect_quiet("R4 release clears", 5);
        ev(7'h15, 1'b1);
        expect_pulse("R8 rearm after release");
        clear_all();
    endtask

    task automatic t_three();  // R3
        wr(0, 1'b1, 7'h01);
        wr(1, 1'b1, 7'h7F);
        wr(2, 1'b1, 7'h40);
        ev(7'h01, 1'b1);
        ev(7'h7F, 1'b1);
        expect_quiet("R3 two of three", 5);
        ev(7'h01, 1'b0);
        ev(7'h40, 1'b1);
        expect_quiet("R3 first released", 5);
        ev(7'h01, 1'b1);
        expect_pulse("R3 all three");
        clear_all();
    endtask

    task automatic t_level0();  // R5
        wr(0, 1'b0, 7'h22);
        ev(7'h22, 1'b1);
        expect_quiet("R5 active does not set", 5);
        ev(7'h22, 1'b0);
        expect_pulse("R5 inactive sets");
        ev(7'h22, 1'b1);
        ev(7'h22, 1'b0);
        expect_pulse("R5 active clears then inactive sets");
        clear_all();
    endtask

    task automatic t_disabled_and_sel3();  // R2 R1
        wr(3, 1'b1, 7'h11);
        ev(7'h11, 1'b1);
        expect_quiet("R1 sel 3 loads nothing", 5);
        wr(0, 1'b1, 7'h05);
        wr(2, 1'b1, 7'h06);
        ev(7'h05, 1'b1);
        expect_quiet("R2 partial", 4);
        ev(7'h06, 1'b1);
        expect_pulse("R2 zero slot ignored");
        clear_all();
    endtask

    task automatic t_write_clear();  // R9 R10
        wr(0, 1'b1, 7'h0A);
        wr(1, 1'b1, 7'h0B);
        ev(7'h0A, 1'b1);
        wr(0, 1'b1, 7'h0A);
        ev(7'h0C, 1'b1);
        ev(7'h00, 1'b1);
        ev(7'h0B, 1'b1);
        expect_quiet("R9 rewrite clears held", 6);
        // Same-cycle write and matching event on slot 0.
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_data = {1'b1, 7'h0A};
        evt_valid = 1'b1; evt_code = 7'h0A; evt_press = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; evt_valid = 1'b0;
        expect_quiet("R9 write wins over event", 6);
        ev(7'h0A, 1'b1);
        expect_pulse("R10 fires after real event");
        clear_all();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_zero();
        t_single();
        t_three();
        t_level0();
        t_disabled_and_sel3();
        t_write_clear();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule